// File: doc/BRIEF.md
# Serial Memory Write-Protection and Status Controller

This block holds the status byte of a byte-addressed serial nonvolatile memory. It decides, for every write the command decoder wants to commit, whether that write may proceed. It keeps four bits that a real part would hold in nonvolatile cells: a three-bit lock code and a pin-enable bit. Here they live in flops, with a parameterised reset value. It also keeps two volatile flags: a write-enable latch and a busy flag. The self-timed internal programming cycle is modelled as a down-counter that runs for a parameterised number of clocks.

The command decoder drives the block with single-cycle pulses:
- set latch;
- clear latch;
- status byte received, with its data;
- frame end, which is the chip deselect that launches a staged status write;
- array commit, with a byte address.

The block returns three things: the status byte for reads, a permit for the presented address, and a permit for status writes. The lock code protects one of two kinds of region. Codes 001 to 011 protect upper fractions of the array. Codes 100 to 111 protect the first 1, 2, 4 or 8 pages. An external protect pin, combined with the pin-enable bit, freezes the status bits. Because the pin-enable bit cannot be cleared while the pin is held low, the protected region becomes permanent read-only storage.

Top module: `nvwp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 with the default nonvolatile reset value. The layout is: bit 7 pin-enable, bits 6:5 always 0, bits 4:2 lock code, bit 1 write-enable latch, bit 0 busy. Both permits are 0 after reset.
- R2: A set-latch pulse sets the write-enable latch and a clear-latch pulse clears it. When both arrive in the same cycle, the clear wins.
- R3: The upper-fraction lock codes protect these address ranges: 000 nothing, 001 0x6000–0x7FFF, 010 0x4000–0x7FFF, 011 every address. `addr_wr_ok_o` is 1 only when the latch is set, no cycle runs and the address is unprotected.
- R4: The first-page lock codes protect these address ranges (64-byte pages): 100 0x000–0x03F, 101 0x000–0x07F, 110 0x000–0x0FF, 111 0x000–0x1FF.
- R5: An array commit is refused when the latch is 0, when the address is protected, or when a cycle is running. A refused commit does not raise busy and leaves the latch unchanged.
- R6: An accepted commit raises busy from the next clock for exactly WR_CYCLES clocks. A further commit during that time does not extend it. The latch is cleared when the cycle ends.
- R7: While busy, the status byte reads 0xFF.
- R8: A staged status byte is applied at frame end. Only bits 7 and 4:2 are taken; data bits 6, 5, 1 and 0 are ignored. The write starts a timed cycle, and the latch is cleared when that cycle ends.
- R9: Hardware protection is active when the protect pin is low and pin-enable is 1. While it is active, status writes are refused and `sr_wr_ok_o` is 0. With pin-enable 0, a low pin has no effect.
- R10: With pin-enable 1, the pin going low between the status byte and frame end cancels the status write. The pin going low after the cycle has started has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_pin_i | input | 1 | Protect pin level; low requests hardware protection |
| wel_set_i | input | 1 | Pulse: set the write-enable latch |
| wel_clr_i | input | 1 | Pulse: clear the write-enable latch |
| sr_load_i | input | 1 | Pulse: a status data byte has been received |
| sr_data_i | input | 8 | Status data byte accompanying `sr_load_i` |
| frame_end_i | input | 1 | Pulse: chip deselect that launches a staged status write |
| arr_commit_i | input | 1 | Pulse: request to start an array write at `addr_i` |
| addr_i | input | ADDR_W | Byte address under test or being committed |
| status_o | output | 8 | Status byte for reads |
| addr_wr_ok_o | output | 1 | Array write permitted at `addr_i` |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
The hardest case to reach is a protect-pin fall that lands inside the short window between a received status byte and the frame end that would launch it. The stimulus first sets pin-enable through an ordinary status write. It then stages a byte, drops and raises the pin over exactly one clock, and issues the frame end. The bench checks that no cycle starts and that the latch survives. A second pass drops the pin only after launch and checks that the new bits still land. The busy window is measured by counting busy samples clock by clock, with a second commit injected partway through the window.

// File: rtl/nvwp_pkg.sv
package nvwp_pkg;

   typedef logic [2:0] lock_code_t;

   typedef struct packed {
      logic       wpen;
      lock_code_t lock;
   } nv_bits_t;

   localparam int unsigned SR_W       = 8;
   localparam int unsigned SR_WPEN    = 7;
   localparam int unsigned SR_LOCK_HI = 4;
   localparam int unsigned SR_LOCK_LO = 2;

   function automatic logic [SR_W-1:0] pack_status(input nv_bits_t nv, input logic wel);
      logic [SR_W-1:0] s;
      s = '0;
      s[SR_WPEN] = nv.wpen;
      s[SR_LOCK_HI:SR_LOCK_LO] = nv.lock;
      s[1] = wel;
      return s;
   endfunction

endpackage

// File: rtl/nvwp_lock_decode.sv
module nvwp_lock_decode
   import nvwp_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned PAGE_W = 6
) (
   input  lock_code_t        code_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              locked_o
);
   localparam int unsigned PG_W   = ADDR_W - PAGE_W;
   localparam int unsigned N_PGEN = 4;

   initial begin : p_cfg
      AST_CFG_GEOMETRY: assert (ADDR_W >= PAGE_W + N_PGEN && ADDR_W >= 2)
         else $error("address width too small for the page-lock codes");
   end

   logic [PG_W-1:0]   page_idx;
   logic [N_PGEN-1:0] first_hit;
   logic              upper_q4;
   logic              upper_half;

   assign page_idx   = addr_i[ADDR_W-1:PAGE_W];
   assign upper_q4   = &addr_i[ADDR_W-1 -: 2];
   assign upper_half = addr_i[ADDR_W-1];

   // first_hit[k]: address lies in the first 2**k pages
   for (genvar k = 0; k < N_PGEN; k++) begin : g_page
      assign first_hit[k] = ((page_idx >> k) == {PG_W{1'b0}});
   end

   always_comb begin
      unique case (code_i)
         3'b000:  locked_o = 1'b0;
         3'b001:  locked_o = upper_q4;
         3'b010:  locked_o = upper_half;
         3'b011:  locked_o = 1'b1;
         default: locked_o = first_hit[code_i[1:0]];
      endcase
   end

endmodule

// File: rtl/nvwp_write_timer.sv
module nvwp_write_timer #(
   parameter int unsigned CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int unsigned CNT_W = $clog2(CYCLES + 1);

   initial begin : p_cfg
      AST_CFG_CYCLES: assert (CYCLES >= 1) else $error("write cycle length must be at least one clock");
   end

   if (CYCLES == 1) begin : g_single
      logic busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= start_i;
      end
      assign busy_o = busy_q;
      assign done_o = busy_q;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (start_i)       cnt_q <= CNT_W'(CYCLES);
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign busy_o = (cnt_q != '0);
      assign done_o = (cnt_q == CNT_W'(1));
   end

   AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o); // R6
   AST_TMR_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !busy_o); // R6

endmodule

// File: rtl/nvwp_ctrl.sv
module nvwp_ctrl
   import nvwp_pkg::*;
#(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned PAGE_W    = 6,
   parameter int unsigned WR_CYCLES = 8,
   parameter logic [3:0]  NV_RESET  = 4'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_pin_i,
   input  logic              wel_set_i,
   input  logic              wel_clr_i,
   input  logic              sr_load_i,
   input  logic [7:0]        sr_data_i,
   input  logic              frame_end_i,
   input  logic              arr_commit_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [7:0]        status_o,
   output logic              addr_wr_ok_o,
   output logic              sr_wr_ok_o
);
   localparam nv_bits_t NV_INIT = nv_bits_t'(NV_RESET);

   nv_bits_t nv_q, pend_data_q;
   logic     wel_q, pend_q;
   logic     busy, done, locked, hw_prot;
   logic     sr_ok, arr_ok, arr_go, sr_go, start;
   logic     unused_data;

   assign unused_data = ^{sr_data_i[6:5], sr_data_i[1:0]};

   nvwp_lock_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_decode (
      .code_i   (nv_q.lock),
      .addr_i   (addr_i),
      .locked_o (locked)
   );

   nvwp_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .busy_o  (busy),
      .done_o  (done)
   );

   assign hw_prot = !wp_pin_i && nv_q.wpen;
   assign sr_ok   = wel_q && !busy && !hw_prot;
   assign arr_ok  = wel_q && !busy && !locked;
   assign arr_go  = arr_commit_i && arr_ok;
   assign sr_go   = frame_end_i && pend_q && sr_ok;
   assign start   = arr_go || sr_go;

   // staged status byte, cancelled by protection or frame end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_data_q <= NV_INIT;
      end else if (hw_prot || frame_end_i) begin
         pend_q <= 1'b0;
      end else if (sr_load_i && sr_ok) begin
         pend_q      <= 1'b1;
         pend_data_q <= '{wpen: sr_data_i[SR_WPEN], lock: sr_data_i[SR_LOCK_HI:SR_LOCK_LO]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     nv_q <= NV_INIT;
      else if (sr_go) nv_q <= pend_data_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              wel_q <= 1'b0;
      else if (done)           wel_q <= 1'b0;
      else if (busy || start)  wel_q <= wel_q;
      else if (wel_clr_i)      wel_q <= 1'b0;
      else if (wel_set_i)      wel_q <= 1'b1;
   end

   assign status_o     = busy ? 8'hFF : pack_status(nv_q, wel_q);
   assign addr_wr_ok_o = arr_ok;
   assign sr_wr_ok_o   = sr_ok;

   AST_WEL_GONE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel_q); // R6
   AST_CYCLE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wel_q)); // R5
   AST_NO_LOCKED_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_commit_i && locked && !frame_end_i) |=> !$rose(busy)); // R5
   AST_SR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      hw_prot |=> $stable(nv_q)); // R9
   AST_PIN_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && hw_prot) |=> !pend_q); // R10

endmodule

// File: tb/nvwp_ctrl_bench.sv
module nvwp_ctrl_bench;
   localparam int unsigned ADDR_W = 15;
   localparam int unsigned N      = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wp_pin = 1'b1;
   logic              wel_set = 1'b0, wel_clr = 1'b0;
   logic              sr_load = 1'b0, frame_end = 1'b0, arr_commit = 1'b0;
   logic [7:0]        sr_data = 8'h00;
   logic [ADDR_W-1:0] addr = '0;
   logic [7:0]        status;
   logic              addr_ok, sr_ok;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   nvwp_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(6), .WR_CYCLES(N), .NV_RESET(4'h0)) u_nvwp_ctrl (
      .clk(clk), .rst_n(rst_n), .wp_pin_i(wp_pin),
      .wel_set_i(wel_set), .wel_clr_i(wel_clr),
      .sr_load_i(sr_load), .sr_data_i(sr_data), .frame_end_i(frame_end),
      .arr_commit_i(arr_commit), .addr_i(addr),
      .status_o(status), .addr_wr_ok_o(addr_ok), .sr_wr_ok_o(sr_ok)
   );

   // {lock code, address, expected protected}
   localparam logic [18:0] VEC [0:15] = '{
      {3'd0, 15'h0000, 1'b0}, {3'd0, 15'h7FFF, 1'b0},
      {3'd1, 15'h5FFF, 1'b0}, {3'd1, 15'h6000, 1'b1},
      {3'd2, 15'h3FFF, 1'b0}, {3'd2, 15'h4000, 1'b1},
      {3'd3, 15'h0000, 1'b1}, {3'd3, 15'h2345, 1'b1},
      {3'd4, 15'h003F, 1'b1}, {3'd4, 15'h0040, 1'b0},
      {3'd5, 15'h007F, 1'b1}, {3'd5, 15'h0080, 1'b0},
      {3'd6, 15'h00FF, 1'b1}, {3'd6, 15'h0100, 1'b0},
      {3'd7, 15'h01FF, 1'b1}, {3'd7, 15'h0200, 1'b0}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse_set();
      @(negedge clk) wel_set = 1'b1;
      @(negedge clk) wel_set = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk) wel_clr = 1'b1;
      @(negedge clk) wel_clr = 1'b0;
   endtask

   task automatic load_byte(input logic [7:0] d);
      @(negedge clk) begin sr_load = 1'b1; sr_data = d; end
      @(negedge clk) sr_load = 1'b0;
   endtask

   task automatic end_frame();
      @(negedge clk) frame_end = 1'b1;
      @(negedge clk) frame_end = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4 * N && status == 8'hFF; i++) @(negedge clk);
   endtask

   task automatic sr_write(input logic [7:0] d);
      load_byte(d);
      end_frame();
      wait_idle();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [2:0] cur;
      int         busy_cnt;
      cur = 3'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after reset", 16'(status), 16'h00);
      chk("R1 sr permit after reset", 16'(sr_ok), 16'h0);
      chk("R1 addr permit after reset", 16'(addr_ok), 16'h0);

      // R2 latch control
      pulse_set();
      chk("R2 set latch", 16'(status), 16'h02);
      pulse_clr();
      chk("R2 clear latch", 16'(status), 16'h00);
      pulse_set();
      @(negedge clk) begin wel_set = 1'b1; wel_clr = 1'b1; end
      @(negedge clk) begin wel_set = 1'b0; wel_clr = 1'b0; end
      chk("R2 clear wins over set", 16'(status), 16'h00);

      // R5 commit with latch clear
      addr = 15'h1234;
      @(negedge clk) arr_commit = 1'b1;
      @(negedge clk) arr_commit = 1'b0;
      chk("R5 commit without latch refused", 16'(status), 16'h00);

      // R3 / R4 table walk
      for (int v = 0; v < 16; v++) begin
         logic [2:0]        code;
         logic [ADDR_W-1:0] a;
         logic              prot;
         {code, a, prot} = VEC[v];
         if (code != cur) begin
            pulse_set();
            sr_write({3'b000, code, 2'b00});
            cur = code;
         end
         addr = a;
         pulse_set();
         if (code[2]) chk($sformatf("R4 code %0d addr %h", code, a), 16'(addr_ok), 16'(!prot));
         else         chk($sformatf("R3 code %0d addr %h", code, a), 16'(addr_ok), 16'(!prot));
         chk("R3 lock field readback", 16'(status), 16'({3'b000, code, 2'b10}));
         pulse_clr();
      end

      // R5 locked address refused (code 111 locks 0x000-0x1FF)
      pulse_set();
      addr = 15'h0010;
      @(negedge clk) arr_commit = 1'b1;
      @(negedge clk) arr_commit = 1'b0;
      chk("R5 locked commit refused, latch kept", 16'(status), 16'h1E);

      // R6 / R7 timed cycle, second commit mid-cycle ignored
      addr = 15'h4000;
      @(negedge clk) arr_commit = 1'b1;
      @(negedge clk) arr_commit = 1'b0;
      chk("R7 status all ones while busy", 16'(status), 16'hFF);
      busy_cnt = 0;
      for (int i = 0; i < N + 4; i++) begin
         if (status == 8'hFF) busy_cnt++;
         arr_commit = (i == 2);
         @(negedge clk);
      end
      arr_commit = 1'b0;
      chk("R6 busy length", 16'(busy_cnt), 16'(N));
      chk("R6 latch cleared after cycle", 16'(status), 16'h1C);

      // R8 status write ignores bits 6,5,1,0
      pulse_set();
      sr_write(8'hFF);
      chk("R8 status write masked", 16'(status), 16'h9C);

      // R9 hardware protection
      wp_pin = 1'b0;
      pulse_set();
      chk("R9 latch set under protection", 16'(status), 16'h9E);
      chk("R9 sr permit low", 16'(sr_ok), 16'h0);
      sr_write(8'h00);
      chk("R9 status write refused", 16'(status), 16'h9E);
      wp_pin = 1'b1;
      @(negedge clk);
      chk("R9 sr permit with pin high", 16'(sr_ok), 16'h1);
      sr_write(8'h00);
      chk("R9 write with pin high", 16'(status), 16'h00);
      wp_pin = 1'b0;
      pulse_set();
      sr_write(8'h04);
      chk("R9 pin ignored when enable clear", 16'(status), 16'h04);

      // R10 pin fall between byte and frame end cancels
      wp_pin = 1'b1;
      pulse_set();
      sr_write(8'h84);
      chk("R10 setup enable", 16'(status), 16'h84);
      pulse_set();
      load_byte(8'h00);
      @(negedge clk) wp_pin = 1'b0;
      @(negedge clk) wp_pin = 1'b1;
      end_frame();
      chk("R10 cancelled write leaves status", 16'(status), 16'h86);
      load_byte(8'h88);
      @(negedge clk) frame_end = 1'b1;
      @(negedge clk) begin frame_end = 1'b0; wp_pin = 1'b0; end
      wait_idle();
      wp_pin = 1'b1;
      chk("R10 pin fall after start has no effect", 16'(status), 16'h88);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule